// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block owns the receive packet memory of a network controller. The memory is treated as a ring of 256-byte pages, running from a boundary page up to a high boundary page. Incoming frames arrive one byte per cycle. Each frame is stored starting four bytes into the page named by the write page pointer, and its bytes run on linearly, wrapping from the last byte of the high boundary page to the first byte of the boundary page. When the frame ends, the block writes a packed 32-bit descriptor into the first four bytes of the frame's starting page. The descriptor holds the page that follows the frame, the frame length and a status byte. The block then moves the write page pointer to that following page.

The host reads frames through a byte-addressed memory read port. It moves through the ring with a byte-wide register port that exposes both 12-bit page pointers. To release a frame, the host copies the descriptor's next-page field into the read page pointer. The ring is empty whenever the two pointers are equal. A frame that would reach the page the host has not yet released is dropped without touching memory. The drop is marked in the status of the next frame that is stored.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the write and read page pointers both equal the boundary page (default 1). Register addresses read as follows: 0 gives write pointer bits 7:0, 1 gives {4'b0, write pointer bits 11:8}, 2 gives read pointer bits 7:0, and 3 gives {4'b0, read pointer bits 11:8}.
- R2: Data byte i of a stored frame sits at byte offset 4+i counted linearly from the start of its starting page. Bytes past the last byte of the high boundary page (default 15) continue at byte 0 of the boundary page.
- R3: The descriptor occupies offsets 0..3 of the starting page. Byte 0 is next[7:0], byte 1 is {len[3:0], next[11:8]}, byte 2 is len[11:4] and byte 3 is the status byte.
- R4: The next page is the page that follows the page holding the last data byte, with wrap. When a frame is stored, the write pointer takes this value and frame_done pulses for one cycle, in the cycle after the end-of-frame beat.
- R5: Status bits are defined as follows. Bit 7 equals in_err on the end-of-frame beat. Bit 6 is set when the length is below 60. Bit 0 is set when at least one frame was dropped since the previous stored frame. All other bits are 0.
- R6: A frame needs n = ceil((len+4)/256) pages. Let free be the number of pages from the write pointer forward to the read pointer, or the whole ring when the ring is empty. When n >= free, the frame is dropped: unread memory and the write pointer stay unchanged, and frame_drop pulses for one cycle after the end-of-frame beat.
- R7: rd_data returns the memory byte at rd_addr one cycle after the address is applied. Address = page*256 + offset.
- R8: Host writes to register addresses 2 and 3 update the read pointer. Writes to addresses 0 and 1 are ignored while a frame is in progress.
- R9: ring_empty is 1 exactly when the write and read pointers are equal. It is 0 after a stored frame until the host releases that frame.
- R10: Beats with in_valid set outside a frame and without in_sof are ignored. An in_sof in the middle of a frame abandons the partial frame and starts a new one at the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Receive error, sampled with in_eof |
| in_data | input | 8 | Frame byte |
| rd_addr | input | AW (12) | Host memory byte address |
| rd_data | output | 8 | Host memory byte, one cycle later |
| reg_we | input | 1 | Pointer register write strobe |
| reg_addr | input | 2 | Pointer register byte select |
| reg_wdata | input | 8 | Pointer register write data |
| reg_rdata | output | 8 | Pointer register read data (combinational) |
| frame_done | output | 1 | One-cycle pulse: frame stored |
| frame_drop | output | 1 | One-cycle pulse: frame dropped |
| ring_empty | output | 1 | Write pointer equals read pointer |

## Verification
frame_done and frame_drop are due in the cycle after the edge that takes the end-of-frame beat. The bench drives each beat on a falling edge and samples both pulses on the very next falling edge. Memory reads are due one cycle after the address: the bench applies rd_addr on one falling edge and reads rd_data on the next. Register reads are combinational and are sampled shortly after the address changes. A pointer written through the register port, or moved by a commit, is read back only after the edge that stores it.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int MEM_PAGES = 16,
  parameter int BND_PAGE  = 1,
  parameter int HI_PAGE   = 15,
  parameter int RUNT_MIN  = 60,
  parameter int AW        = $clog2(MEM_PAGES) + 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          frame_done,
  output logic          frame_drop,
  output logic          ring_empty
);
  localparam int PGW = AW - 8;

  logic [7:0]  mem [MEM_PAGES*256];
  logic [11:0] wp, rp, start_pg, pg, len;
  logic [7:0]  off;
  logic        active, ovf, lost;

  function automatic logic [11:0] step(input logic [11:0] p);
    return (p == 12'(HI_PAGE)) ? 12'(BND_PAGE) : p + 12'd1;
  endfunction

  logic        beat, busy, adv, ovf_n, drop_n, cur_ovf;
  logic [11:0] cur_pg, cur_start, cur_len, pg_after, end_pg, len_n;
  logic [7:0]  cur_off, status;
  logic [31:0] desc;

  assign beat      = in_valid && (in_sof || active);
  assign busy      = active || beat;
  assign cur_pg    = in_sof ? wp : pg;
  assign cur_start = in_sof ? wp : start_pg;
  assign cur_off   = in_sof ? 8'd4 : off;
  assign cur_len   = in_sof ? 12'd0 : len;
  assign cur_ovf   = in_sof ? 1'b0 : ovf;
  assign adv       = (cur_off == 8'hFF);
  assign pg_after  = adv ? step(cur_pg) : cur_pg;
  assign ovf_n     = cur_ovf || (adv && (pg_after == rp || pg_after == cur_start));
  assign end_pg    = adv ? pg_after : step(cur_pg);
  assign drop_n    = ovf_n || (!adv && (end_pg == rp || end_pg == cur_start));
  assign len_n     = cur_len + 12'd1;
  assign status    = {in_err, (len_n < 12'(RUNT_MIN)), 5'b0, lost};
  assign desc      = {status, len_n, end_pg};
  assign ring_empty = (wp == rp);

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = wp[7:0];
      2'd1: reg_rdata = {4'b0, wp[11:8]};
      2'd2: reg_rdata = rp[7:0];
      default: reg_rdata = {4'b0, rp[11:8]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (beat && !cur_ovf)
      mem[{cur_pg[PGW-1:0], cur_off}] <= in_data;
    if (beat && in_eof && !drop_n)
      for (int k = 0; k < 4; k++)
        mem[{cur_start[PGW-1:0], 8'(k)}] <= desc[8*k +: 8];
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= 12'(BND_PAGE);
      rp <= 12'(BND_PAGE);
      start_pg <= '0;
      pg <= '0;
      len <= '0;
      off <= '0;
      active <= 1'b0;
      ovf <= 1'b0;
      lost <= 1'b0;
      frame_done <= 1'b0;
      frame_drop <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      frame_drop <= 1'b0;
      if (beat) begin
        active   <= !in_eof;
        start_pg <= cur_start;
        pg       <= pg_after;
        off      <= cur_off + 8'd1;
        ovf      <= ovf_n;
        len      <= len_n;
        if (in_eof) begin
          if (drop_n) begin
            frame_drop <= 1'b1;
            lost <= 1'b1;
          end else begin
            frame_done <= 1'b1;
            wp <= end_pg;
            lost <= 1'b0;
          end
        end
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: if (!busy) wp[7:0] <= reg_wdata;
          2'd1: if (!busy) wp[11:8] <= reg_wdata[3:0];
          2'd2: rp[7:0] <= reg_wdata;
          default: rp[11:8] <= reg_wdata[3:0];
        endcase
      end
    end
  end
endmodule

module rx_page_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_eof,
  input logic        reg_we,
  input logic        frame_done,
  input logic        frame_drop,
  input logic        ring_empty,
  input logic [11:0] wp
);
  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid && in_eof)); // R4
  AST_DROP_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> $past(in_valid && in_eof)); // R6
  AST_DONE_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_drop)); // R6
  AST_DROP_KEEPS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_drop && !$past(reg_we)) |-> (wp == $past(wp))); // R6
  AST_COMMIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !$past(reg_we)) |-> !ring_empty); // R9
endmodule

bind rx_page_ring rx_page_ring_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .reg_we(reg_we), .frame_done(frame_done), .frame_drop(frame_drop),
  .ring_empty(ring_empty), .wp(wp)
);

// File: tb/rx_page_ring_tb_top.sv
`timescale 1ns/1ps
module rx_page_ring_tb_top;
  localparam int BND = 1;
  localparam int HI  = 15;
  localparam int R   = HI - BND + 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic [11:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic frame_done, frame_drop, ring_empty;

  rx_page_ring dut_i (.*);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  int m_wp = BND, m_rp = BND;
  bit m_lost = 0;
  logic [7:0] exp_mem [4096];
  logic [7:0] fb [4096];
  int q_start [64], q_len [64], q_next [64], q_stat [64];
  int qh = 0, qt = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int adv_pages(input int p, input int n);
    return BND + ((p - BND + n) % R);
  endfunction
  function automatic int pages_needed(input int len);
    return (len + 4 + 255) / 256;
  endfunction
  function automatic int free_pages(input int w, input int r);
    int d = (r - w + R) % R;
    return (d == 0) ? R : d;
  endfunction
  function automatic int byte_addr(input int start, input int lin);
    int a = ((start - BND) * 256 + lin) % (R * 256);
    return (BND + a / 256) * 256 + a % 256;
  endfunction

  task automatic reg_read(input int a, output int v);
    @(negedge clk); reg_addr = 2'(a); #1 v = int'(reg_rdata);
  endtask
  task automatic reg_write(input int a, input int v);
    @(negedge clk); reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(v);
    @(negedge clk); reg_we = 0;
  endtask
  task automatic mem_read(input int a, output int v);
    @(negedge clk); rd_addr = 12'(a);
    @(negedge clk); v = int'(rd_data);
  endtask

  task automatic send_frame(input int len, input bit err, input bit poke);
    bit exp_drop;
    int n, nxt, st;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_err = err && (i == len - 1); in_data = fb[i];
      reg_we = poke && (i == len / 2); reg_addr = 2'd0; reg_wdata = 8'hAB;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; reg_we = 0;
    n = pages_needed(len);
    exp_drop = (n >= free_pages(m_wp, m_rp));
    check(frame_done == !exp_drop, "R4", "frame_done pulse", int'(frame_done), int'(!exp_drop));
    check(frame_drop == exp_drop, "R6", "frame_drop pulse", int'(frame_drop), int'(exp_drop));
    if (exp_drop) m_lost = 1;
    else begin
      nxt = adv_pages(m_wp, n);
      st = (err ? 128 : 0) | (len < 60 ? 64 : 0) | (m_lost ? 1 : 0);
      for (int i = 0; i < len; i++) exp_mem[byte_addr(m_wp, 4 + i)] = fb[i];
      q_start[qt % 64] = m_wp; q_len[qt % 64] = len; q_next[qt % 64] = nxt; q_stat[qt % 64] = st;
      qt++;
      m_wp = nxt; m_lost = 0;
    end
  endtask

  task automatic consume_one();
    int s, d, v, bad, got;
    int exp_w;
    s = q_start[qh % 64];
    exp_w = (q_stat[qh % 64] << 24) | (q_len[qh % 64] << 12) | q_next[qh % 64];
    got = 0;
    for (int k = 0; k < 4; k++) begin
      mem_read(s * 256 + k, v);
      got = got | (v << (8 * k));
    end
    check(got == exp_w, "R3", "descriptor word (R5 status in top byte)", got, exp_w);
    bad = 0;
    for (int i = 0; i < q_len[qh % 64]; i++) begin
      d = byte_addr(s, 4 + i);
      mem_read(d, v);
      if (v != int'(exp_mem[d])) bad++;
    end
    check(bad == 0, "R2", "data bytes mismatched (R7 read path)", bad, 0);
    reg_write(2, q_next[qh % 64] & 255);
    reg_write(3, q_next[qh % 64] >> 8);
    m_rp = q_next[qh % 64];
    qh++;
  endtask

  task automatic check_ptrs(input string tag);
    int lo, hi, e;
    reg_read(0, lo); reg_read(1, hi);
    check((hi << 8 | lo) == m_wp, tag, "write pointer", hi << 8 | lo, m_wp);
    reg_read(2, lo); reg_read(3, hi);
    check((hi << 8 | lo) == m_rp, tag, "read pointer", hi << 8 | lo, m_rp);
    e = (m_wp == m_rp) ? 1 : 0;
    check(int'(ring_empty) == e, "R9", "ring_empty", int'(ring_empty), e);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state and register layout
    reg_read(1, v); check(v == 0, "R1", "wp high byte", v, 0);
    reg_read(3, v); check(v == 0, "R1", "rp high byte", v, 0);
    check_ptrs("R1");
    // R10: stray beats without start are ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'h5A; in_eof = (i == 4);
    end
    @(negedge clk); in_valid = 0; in_eof = 0;
    check(!frame_done && !frame_drop, "R10", "pulse on stray beats", int'(frame_done | frame_drop), 0);
    check_ptrs("R10");
    // R5: runt frame, then R5 error frame of exactly 60 bytes
    send_frame(10, 0, 0);
    check_ptrs("R4");
    consume_one();
    check_ptrs("R9");
    send_frame(60, 1, 0);
    consume_one();
    // R8: write-pointer poke mid-frame is ignored
    send_frame(300, 0, 1);
    check_ptrs("R8");
    consume_one();
    // R10: abandoned partial frame then full frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; in_sof = (i == 0); in_data = 8'(i);
    end
    @(negedge clk); in_valid = 0; in_sof = 0;
    send_frame(20, 0, 0);
    check_ptrs("R10");
    consume_one();
    // R6: fill the ring until a drop, then R5 lost flag on next stored frame
    for (int f = 0; f < 4; f++) send_frame(1000, 0, 0);
    check_ptrs("R6");
    send_frame(10, 0, 0);
    while (qh != qt) consume_one();
    check_ptrs("R2");
    // random traffic with wrap across the high boundary
    for (int f = 0; f < 50; f++) begin
      send_frame(int'($urandom_range(1, 1200)), 1'($urandom), 0);
      if ($urandom_range(0, 1) == 1) begin
        int k = int'($urandom_range(1, 3));
        while (k > 0 && qh != qt) begin consume_one(); k--; end
      end
    end
    while (qh != qt) consume_one();
    check_ptrs("R9");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule